// File: doc/BRIEF.md
# Coprocessor Power Domain Sequencer

This controller steps a switchable power domain that holds a SIMD coprocessor through its shutdown and wake-up orders. Its outputs are the domain's active-low reset, the output isolation clamp and the power-switch enable. Software raises the shutdown request only after it has blocked coprocessor access, so no vector work is still in flight when the request arrives.

Shutdown runs in three steps. The domain reset is pulled low first. It is held for a fixed minimum number of cycles, and only then is the clamp engaged. Power is removed one cycle after that. Wake-up is accepted only while the main core reset is held. Power is switched on first and a power-good acknowledge is awaited, with a timeout. The clamp is then released, and after it the domain reset. The controller then reports ready until the system releases the core reset.

Any request that arrives out of order is dropped. The output register bank never presents an unsafe combination, whatever the inputs do.

Top module: `simd_pwr_seq`

## Requirements
- R1: During and after controller reset the outputs are: dom_rst_n=0, clamp_en=1, pwr_en=0, dom_off=1, idle=1, ready=0, pwr_err=0, up_rej=0.
- R2: A shutdown request is accepted only while the domain is on (dom_rst_n=1, ready=0, idle=1). One cycle later dom_rst_n=0, clamp_en=0 and pwr_en=1. In every other state the request has no effect.
- R3: During shutdown, dom_rst_n stays low with the clamp off for exactly HOLD_CYCLES cycles (default 8) before clamp_en rises.
- R4: After the clamp rises, power stays on for one more cycle. Then pwr_en=0 and dom_off=1.
- R5: A wake-up request in the off state while core_rst=0 is not acted on. up_rej pulses high for exactly one cycle and the domain stays off.
- R6: A wake-up request in the off state with core_rst=1 sets pwr_en=1 one cycle later, with the clamp still on. The clamp is released on the cycle after pwr_good is seen, and dom_rst_n is still 0 at that point.
- R7: dom_rst_n rises one cycle after the clamp is released, and ready=1 from then on. When core_rst drops, ready clears one cycle later and the domain is on.
- R8: If pwr_good does not arrive within timeout_limit+1 cycles of power-on, the domain returns to off with the clamp still engaged and pwr_err=1. pwr_err stays set until the next accepted wake-up request.
- R9: If core_rst drops while waiting for power-good, the domain returns to off and pwr_err=1.
- R10: dom_rst_n=1 only when clamp_en=0 and pwr_en=1. pwr_en=0 only when clamp_en=1 and dom_rst_n=0.
- R11: idle=1 exactly when the domain is fully on or fully off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| sw_down_req | input | 1 | Software shutdown request, given after access is disabled |
| up_req | input | 1 | Wake-up request |
| core_rst | input | 1 | High while the main core reset is held |
| pwr_good | input | 1 | Power-switch acknowledge |
| timeout_limit | input | CNT_W | Power-good wait limit, in cycles minus one |
| dom_rst_n | output | 1 | Active-low domain reset |
| clamp_en | output | 1 | Output clamp enable |
| pwr_en | output | 1 | Power-switch enable |
| idle | output | 1 | No sequence in progress |
| dom_off | output | 1 | Domain powered off |
| ready | output | 1 | Wake-up done, core reset may be released |
| pwr_err | output | 1 | Sticky power-good timeout or abort flag |
| up_rej | output | 1 | One-cycle pulse for a rejected wake-up |

## Verification
Some rules hold on every cycle, and the bound checker watches those. They are the safe output combinations of R10, the minimum reset hold before any clamp rise of R3, the clamp staying engaged whenever power falls (R4), and ready implying a released domain reset. The bench's scenarios are needed for the rest. These are the exact cycle counts of the hold and timeout windows, the dropping of requests in the wrong state or without core reset, the abort on core reset loss, and the clearing of the sticky error by the next accepted wake-up.

// File: rtl/simd_pwr_seq.sv
module simd_pwr_seq #(
  parameter int HOLD_CYCLES = 8,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_down_req,
  input  logic             up_req,
  input  logic             core_rst,
  input  logic             pwr_good,
  input  logic [CNT_W-1:0] timeout_limit,
  output logic             dom_rst_n,
  output logic             clamp_en,
  output logic             pwr_en,
  output logic             idle,
  output logic             dom_off,
  output logic             ready,
  output logic             pwr_err,
  output logic             up_rej
);
  typedef enum logic [2:0] {
    S_ON, S_HOLD, S_CLAMPED, S_OFF, S_POWERING, S_UNCLAMP, S_READY
  } st_t;

  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

  st_t             st, nxt;
  logic [CNT_W-1:0] cnt;
  logic            fault;
  logic            up_ok;

  assign up_ok = (st == S_OFF) && up_req && core_rst;

  always_comb begin
    nxt   = st;
    fault = 1'b0;
    case (st)
      S_ON:       if (sw_down_req) nxt = S_HOLD;
      S_HOLD:     if (cnt == HOLD_LAST) nxt = S_CLAMPED;
      S_CLAMPED:  nxt = S_OFF;
      S_OFF:      if (up_ok) nxt = S_POWERING;
      S_POWERING: begin
        if (!core_rst) begin
          nxt   = S_OFF;
          fault = 1'b1;
        end else if (pwr_good) begin
          nxt = S_UNCLAMP;
        end else if (cnt == timeout_limit) begin
          nxt   = S_OFF;
          fault = 1'b1;
        end
      end
      S_UNCLAMP:  nxt = S_READY;
      S_READY:    if (!core_rst) nxt = S_ON;
      default:    nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OFF;
      cnt       <= '0;
      dom_rst_n <= 1'b0;
      clamp_en  <= 1'b1;
      pwr_en    <= 1'b0;
      idle      <= 1'b1;
      dom_off   <= 1'b1;
      ready     <= 1'b0;
      pwr_err   <= 1'b0;
      up_rej    <= 1'b0;
    end else begin
      st        <= nxt;
      cnt       <= (nxt != st) ? '0 : cnt + 1'b1;
      dom_rst_n <= (nxt == S_READY) || (nxt == S_ON);
      clamp_en  <= (nxt == S_CLAMPED) || (nxt == S_OFF) || (nxt == S_POWERING);
      pwr_en    <= (nxt != S_OFF);
      idle      <= (nxt == S_ON) || (nxt == S_OFF);
      dom_off   <= (nxt == S_OFF);
      ready     <= (nxt == S_READY);
      up_rej    <= (st == S_OFF) && up_req && !core_rst;
      if (up_ok)      pwr_err <= 1'b0;
      else if (fault) pwr_err <= 1'b1;
    end
  end
endmodule

// File: rtl/simd_pwr_seq_chk.sv
module simd_pwr_seq_chk #(
  parameter int HOLD_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic dom_rst_n,
  input logic clamp_en,
  input logic pwr_en,
  input logic ready
);
  logic [7:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (dom_rst_n)  low_run <= '0;
    else if (low_run != 8'hFF) low_run <= low_run + 1'b1;
  end

  assert_safe_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dom_rst_n |-> (!clamp_en && pwr_en));

  assert_safe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (clamp_en && !dom_rst_n));

  assert_hold_before_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_en) |-> (low_run >= 8'(HOLD_CYCLES)));

  assert_clamp_before_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(clamp_en));

  assert_ready_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (dom_rst_n && !clamp_en));

  assert_unclamp_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_en) |-> (!dom_rst_n || $past(dom_rst_n)));
endmodule

bind simd_pwr_seq simd_pwr_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dom_rst_n(dom_rst_n), .clamp_en(clamp_en),
  .pwr_en(pwr_en), .ready(ready)
);

// File: tb/simd_pwr_seq_bench.sv
`timescale 1ns/1ps
module simd_pwr_seq_bench;
  localparam int HOLD = 8;
  localparam int CW   = 8;

  logic clk = 1'b0;
  logic rst_n, sw_down_req, up_req, core_rst, pwr_good;
  logic [CW-1:0] timeout_limit;
  logic dom_rst_n, clamp_en, pwr_en, idle, dom_off, ready, pwr_err, up_rej;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simd_pwr_seq #(.HOLD_CYCLES(HOLD), .CNT_W(CW)) u_simd_pwr_seq (
    .clk(clk), .rst_n(rst_n), .sw_down_req(sw_down_req), .up_req(up_req),
    .core_rst(core_rst), .pwr_good(pwr_good), .timeout_limit(timeout_limit),
    .dom_rst_n(dom_rst_n), .clamp_en(clamp_en), .pwr_en(pwr_en), .idle(idle),
    .dom_off(dom_off), .ready(ready), .pwr_err(pwr_err), .up_rej(up_rej)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; sw_down_req = 0; up_req = 0; core_rst = 0; pwr_good = 0;
    timeout_limit = 8'd20;
    repeat (3) step();
    chk("R1 dom_rst_n", dom_rst_n, 0);
    chk("R1 clamp_en", clamp_en, 1);
    chk("R1 pwr_en", pwr_en, 0);
    chk("R1 dom_off", dom_off, 1);
    chk("R1 ready/err/rej", {ready, pwr_err, up_rej}, 0);
    chk("R11 idle at reset", idle, 1);
    rst_n = 1'b1;
    step();
    chk("R1 still off after release", dom_off, 1);
  endtask

  task automatic t_reject();
    core_rst = 0; up_req = 1;
    step();
    up_req = 0;
    chk("R5 reject pulse", up_rej, 1);
    chk("R5 stays off", {dom_off, pwr_en}, 2'b10);
    step();
    chk("R5 pulse one cycle", up_rej, 0);
    chk("R5 still off", dom_off, 1);
  endtask

  task automatic t_down_ignored();
    sw_down_req = 1;
    step();
    sw_down_req = 0;
    chk("R2 down ignored when off", {dom_off, pwr_en, clamp_en, dom_rst_n}, 4'b1010);
    step();
    chk("R2 down ignored, idle", idle, 1);
  endtask

  task automatic t_timeout();
    int n;
    timeout_limit = 8'd3; core_rst = 1; up_req = 1;
    step();
    up_req = 0;
    n = 0;
    while (pwr_en && n < 40) begin n++; step(); end
    chk("R8 timeout window", n, 4);
    chk("R8 error set", pwr_err, 1);
    chk("R8 clamp kept", clamp_en, 1);
    step();
    chk("R8 error sticky", pwr_err, 1);
    timeout_limit = 8'd20;
  endtask

  task automatic t_power_up();
    core_rst = 1; up_req = 1;
    step();
    up_req = 0;
    chk("R6 power on first", {pwr_en, clamp_en, dom_rst_n}, 3'b110);
    chk("R8 error cleared", pwr_err, 0);
    chk("R11 busy during wake", idle, 0);
    repeat (2) step();
    chk("R6 clamp held awaiting good", clamp_en, 1);
    pwr_good = 1;
    step();
    pwr_good = 0;
    chk("R6 clamp released in reset", {pwr_en, clamp_en, dom_rst_n}, 3'b100);
    step();
    chk("R7 reset released", dom_rst_n, 1);
    chk("R7 ready", ready, 1);
    step();
    chk("R7 ready held", ready, 1);
    core_rst = 0;
    step();
    chk("R7 ready cleared", ready, 0);
    chk("R11 idle when on", idle, 1);
    chk("R7 domain on", {dom_rst_n, clamp_en, pwr_en}, 3'b101);
  endtask

  task automatic t_up_in_on();
    core_rst = 1; up_req = 1;
    step();
    up_req = 0; core_rst = 0;
    chk("R5 up ignored when on", {dom_rst_n, ready, up_rej, pwr_en}, 4'b1001);
  endtask

  task automatic t_power_down();
    int n;
    sw_down_req = 1;
    step();
    sw_down_req = 0;
    chk("R2 reset first", {dom_rst_n, clamp_en, pwr_en}, 3'b001);
    n = 0;
    while (!clamp_en && n < 40) begin n++; step(); end
    chk("R3 hold cycles", n, HOLD);
    chk("R4 power on while clamped", pwr_en, 1);
    chk("R4 not off yet", dom_off, 0);
    step();
    chk("R4 power removed", {pwr_en, clamp_en, dom_off}, 3'b011);
    chk("R11 idle when off", idle, 1);
  endtask

  task automatic t_abort();
    core_rst = 1; up_req = 1;
    step();
    up_req = 0;
    chk("R9 powering", pwr_en, 1);
    core_rst = 0;
    step();
    chk("R9 abort to off", {pwr_en, dom_off, clamp_en}, 3'b011);
    chk("R9 error set", pwr_err, 1);
  endtask

  initial begin
    t_reset();
    t_reject();
    t_down_ignored();
    t_timeout();
    t_power_up();
    t_up_in_on();
    t_power_down();
    t_abort();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule